// File: doc/BRIEF.md
# Repeating Block Copy, Search and Port Transfer Sequencer

This block runs the repeating string operations of an 8-bit processor core once the instruction has been decoded. It holds three working registers: a 16-bit source pointer, a 16-bit destination pointer and a 16-bit count. The upper byte of the count doubles as the 8-bit count for the port variants. Four operations are supported. A copy moves a memory byte from the source pointer to the destination pointer. A search compares the accumulator with the memory byte at the source pointer and keeps only flags. An input moves a byte from the I/O port into memory at the source pointer. An output sends the memory byte at the source pointer to the I/O port. Two mode bits modify every operation. `step_down` makes the pointers walk downward instead of upward, and `repeat_mode` keeps iterating until the relevant count reaches zero. A repeating search also ends on the first match.

The core loads the initial register values, the accumulator and the mode bits, then pulses `start`. The sequencer drives a byte-wide memory port and a port with a 16-bit address. Each port returns read data one cycle after the request. When the operation ends, the sequencer pulses `done` for one cycle and presents the updated registers and the two flags (`flag_pv`, `flag_z`). These values stay steady until the next start. Interrupt sampling between iterations and instruction decode are handled elsewhere.

The control is a four-state machine:
- `ST_IDLE` (waiting) moves to `ST_FETCH` when `start` is high.
- `ST_FETCH` issues the source read and always moves to `ST_PUT`.
- `ST_PUT` does the write or compare and updates the registers. It returns to `ST_FETCH` when another iteration is due, or moves to `ST_DONE` when the operation ends.
- `ST_DONE` pulses `done` and returns to `ST_IDLE`.

Top module: `blk_xfer_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `io_req`, both flags and the three register outputs are all 0.
- R2: `start` is taken only in `ST_IDLE`. A `start` pulse while `busy` is high has no effect on the running operation or on its final register values.
- R3: Copy (`op_sel`=0) reads memory at the source pointer, then writes that byte to memory at the destination pointer. Both pointers then step by +1, or by -1 when `step_down`=1. The count drops by 1, and `flag_pv` becomes 1 exactly when the new count is nonzero.
- R4: Search (`op_sel`=1) reads memory at the source pointer and issues no write. The source pointer steps, the count drops by 1, and `flag_pv` is set as in R3. `flag_z` becomes 1 when the byte equals `acc`.
- R5: Input (`op_sel`=2) reads the I/O port at the address equal to the full count, with the upper byte on bits 15:8. It writes the byte to memory at the source pointer and steps that pointer. Only the upper count byte drops by 1. `flag_z` becomes 1 when that byte becomes 0.
- R6: Output (`op_sel`=3) reads memory at the source pointer and writes the byte to the I/O port. The port address uses the upper count byte already reduced by 1 and the unchanged lower byte. The pointer steps and `flag_z` follows R5.
- R7: With `repeat_mode`=0, every operation performs exactly one iteration, whatever the count holds.
- R8: With `repeat_mode`=1, copy and search iterate until the 16-bit count reaches 0. Search also stops after the iteration that finds a match.
- R9: With `repeat_mode`=1, input and output iterate until the upper count byte reaches 0. A starting upper byte of 0 gives 256 iterations.
- R10: With `repeat_mode`=1, a copy or search that starts with a count of 0 runs 65536 iterations.
- R11: Each iteration takes exactly two cycles with `busy` high. `done` is a one-cycle pulse that follows the last iteration, and it is never high together with `busy`.
- R12: Copy leaves `flag_z` unchanged, and input and output leave `flag_pv` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken in idle only) |
| op_sel | input | 2 | 0 copy, 1 search, 2 input, 3 output |
| step_down | input | 1 | 1: pointers decrement |
| repeat_mode | input | 1 | 1: iterate until the count is exhausted |
| src_init | input | 16 | Initial source pointer |
| dst_init | input | 16 | Initial destination pointer |
| count_init | input | 16 | Initial count |
| acc | input | 8 | Accumulator value for search |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read |
| io_req | output | 1 | Port access request |
| io_we | output | 1 | Port write (else read) |
| io_addr | output | 16 | Port address |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, valid the cycle after a read |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count_out | output | 16 | Current count |
| flag_pv | output | 1 | Parity/overflow flag result |
| flag_z | output | 1 | Zero flag result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong pointer shows up in the address of the very next port access, no more than two cycles after the bad update. Each access is compared against an independently computed queue of expected writes. A wrong count or a wrong stop decision appears as the wrong number of `busy` cycles and a wrong `count_out` when `done` pulses. A flag that is wrongly updated, or wrongly left alone, is visible in `flag_pv`/`flag_z` at that same pulse. Because the flags are carried from one operation into the next, a flag that should have been left alone is also checked across back-to-back operations.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        OP_COPY   = 2'd0,
        OP_SEARCH = 2'd1,
        OP_IN     = 2'd2,
        OP_OUT    = 2'd3
    } blk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PUT   = 2'd2,
        ST_DONE  = 2'd3
    } blk_state_e;

endpackage

// File: rtl/blk_xfer_step.sv
// Next-value logic for one iteration: pointer stepping, count update,
// flag results and the decision whether another iteration follows.
module blk_xfer_step
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  blk_op_e         op,
    input  logic            step_down,
    input  logic            rpt,
    input  logic [AW-1:0]   src,
    input  logic [AW-1:0]   dst,
    input  logic [CW-1:0]   cnt,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   fetched,
    output logic [AW-1:0]   src_nx,
    output logic [AW-1:0]   dst_nx,
    output logic [CW-1:0]   cnt_nx,
    output logic            pv_wr,
    output logic            pv_val,
    output logic            z_wr,
    output logic            z_val,
    output logic            more
);
    localparam int HW = CW / 2;

    logic [AW-1:0] src_step, dst_step;
    logic [CW-1:0] cnt_dec;
    logic [HW-1:0] hi_dec;
    logic          hit;
    logic          again;

    always_comb begin
        src_step = step_down ? src - AW'(1) : src + AW'(1);
        dst_step = step_down ? dst - AW'(1) : dst + AW'(1);
        cnt_dec  = cnt - CW'(1);
        hi_dec   = cnt[CW-1:HW] - HW'(1);
        hit      = (fetched == acc);

        src_nx = src_step;
        dst_nx = dst;
        cnt_nx = cnt;
        pv_wr  = 1'b0;
        pv_val = 1'b0;
        z_wr   = 1'b0;
        z_val  = 1'b0;
        again  = 1'b0;

        unique case (op)
            OP_COPY: begin
                dst_nx = dst_step;
                cnt_nx = cnt_dec;
                pv_wr  = 1'b1;
                pv_val = |cnt_dec;
                again  = |cnt_dec;
            end
            OP_SEARCH: begin
                cnt_nx = cnt_dec;
                pv_wr  = 1'b1;
                pv_val = |cnt_dec;
                z_wr   = 1'b1;
                z_val  = hit;
                again  = (|cnt_dec) && !hit;
            end
            OP_IN, OP_OUT: begin
                cnt_nx = {hi_dec, cnt[HW-1:0]};
                z_wr   = 1'b1;
                z_val  = ~|hi_dec;
                again  = |hi_dec;
            end
        endcase

        more = rpt && again;
    end

endmodule

// File: rtl/blk_xfer_portmux.sv
// Drives the memory and I/O port strobes from the current state and variant.
module blk_xfer_portmux
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  blk_state_e      state,
    input  blk_op_e         op,
    input  logic [AW-1:0]   src,
    input  logic [AW-1:0]   dst,
    input  logic [CW-1:0]   cnt,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [DW-1:0]   io_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            io_req,
    output logic            io_we,
    output logic [CW-1:0]   io_addr,
    output logic [DW-1:0]   io_wdata,
    output logic [DW-1:0]   fetched
);
    localparam int HW = CW / 2;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        io_req    = 1'b0;
        io_we     = 1'b0;
        io_addr   = '0;
        io_wdata  = '0;
        fetched   = (op == OP_IN) ? io_rdata : mem_rdata;

        if (state == ST_FETCH) begin
            if (op == OP_IN) begin
                io_req  = 1'b1;
                io_addr = cnt;
            end else begin
                mem_req  = 1'b1;
                mem_addr = src;
            end
        end else if (state == ST_PUT) begin
            unique case (op)
                OP_COPY: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = dst;
                    mem_wdata = mem_rdata;
                end
                OP_IN: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = src;
                    mem_wdata = io_rdata;
                end
                OP_OUT: begin
                    io_req   = 1'b1;
                    io_we    = 1'b1;
                    io_addr  = {cnt[CW-1:HW] - HW'(1), cnt[HW-1:0]};
                    io_wdata = mem_rdata;
                end
                OP_SEARCH: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op_sel,
    input  logic            step_down,
    input  logic            repeat_mode,
    input  logic [AW-1:0]   src_init,
    input  logic [AW-1:0]   dst_init,
    input  logic [CW-1:0]   count_init,
    input  logic [DW-1:0]   acc,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            io_req,
    output logic            io_we,
    output logic [CW-1:0]   io_addr,
    output logic [DW-1:0]   io_wdata,
    input  logic [DW-1:0]   io_rdata,
    output logic [AW-1:0]   src_ptr,
    output logic [AW-1:0]   dst_ptr,
    output logic [CW-1:0]   count_out,
    output logic            flag_pv,
    output logic            flag_z,
    output logic            busy,
    output logic            done
);
    blk_state_e    state, state_nx;
    blk_op_e       op_q;
    logic          down_q, rpt_q;
    logic [DW-1:0] acc_q;
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic          pv_q, z_q;

    logic [DW-1:0] fetched;
    logic [AW-1:0] src_nx, dst_nx;
    logic [CW-1:0] cnt_nx;
    logic          pv_wr, pv_val, z_wr, z_val, more;

    blk_xfer_portmux #(.AW(AW), .CW(CW), .DW(DW)) u_ports (
        .state     (state),
        .op        (op_q),
        .src       (src_q),
        .dst       (dst_q),
        .cnt       (cnt_q),
        .mem_rdata (mem_rdata),
        .io_rdata  (io_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .io_req    (io_req),
        .io_we     (io_we),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .fetched   (fetched)
    );

    blk_xfer_step #(.AW(AW), .CW(CW), .DW(DW)) u_step (
        .op        (op_q),
        .step_down (down_q),
        .rpt       (rpt_q),
        .src       (src_q),
        .dst       (dst_q),
        .cnt       (cnt_q),
        .acc       (acc_q),
        .fetched   (fetched),
        .src_nx    (src_nx),
        .dst_nx    (dst_nx),
        .cnt_nx    (cnt_nx),
        .pv_wr     (pv_wr),
        .pv_val    (pv_val),
        .z_wr      (z_wr),
        .z_val     (z_val),
        .more      (more)
    );

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = start ? ST_FETCH : ST_IDLE;
            ST_FETCH: state_nx = ST_PUT;
            ST_PUT:   state_nx = more ? ST_FETCH : ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_COPY;
            down_q <= 1'b0;
            rpt_q  <= 1'b0;
            acc_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            pv_q   <= 1'b0;
            z_q    <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            op_q   <= blk_op_e'(op_sel);
            down_q <= step_down;
            rpt_q  <= repeat_mode;
            acc_q  <= acc;
            src_q  <= src_init;
            dst_q  <= dst_init;
            cnt_q  <= count_init;
        end else if (state == ST_PUT) begin
            src_q <= src_nx;
            dst_q <= dst_nx;
            cnt_q <= cnt_nx;
            if (pv_wr) pv_q <= pv_val;
            if (z_wr)  z_q  <= z_val;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state == ST_FETCH) || (state == ST_PUT);
        done      = (state == ST_DONE);
        src_ptr   = src_q;
        dst_ptr   = dst_q;
        count_out = cnt_q;
        flag_pv   = pv_q;
        flag_z    = z_q;
    end

endmodule

// File: rtl/blk_xfer_engine_chk.sv
module blk_xfer_engine_chk
    import blk_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          io_req,
    input logic          io_we,
    input logic [CW-1:0] io_addr,
    input logic [AW-1:0] src_ptr,
    input logic [CW-1:0] count_out,
    input blk_state_e    state,
    input blk_op_e       op_q
);
    localparam int HW = CW / 2;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !io_req));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4
    search_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (op_q != OP_SEARCH));

    // R5
    in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_we) |-> (io_addr == count_out));

    // R6
    out_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && io_we) |-> (io_addr[CW-1:HW] == count_out[CW-1:HW] - HW'(1)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(src_ptr) && $stable(count_out)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUT && (op_q == OP_COPY || op_q == OP_SEARCH))
        |=> (count_out == $past(count_out) - CW'(1)));

endmodule

bind blk_xfer_engine blk_xfer_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .io_req    (io_req),
    .io_we     (io_we),
    .io_addr   (io_addr),
    .src_ptr   (src_ptr),
    .count_out (count_out),
    .state     (state),
    .op_q      (op_q)
);

// File: tb/blk_xfer_engine_tb.sv
module blk_xfer_engine_tb;
    import blk_xfer_pkg::*;

    logic        clk, rst_n, start;
    logic [1:0]  op_sel;
    logic        step_down, repeat_mode;
    logic [15:0] src_init, dst_init, count_init;
    logic [7:0]  acc;
    logic        mem_req, mem_we, io_req, io_we;
    logic [15:0] mem_addr, io_addr;
    logic [7:0]  mem_wdata, mem_rdata, io_wdata, io_rdata;
    logic [15:0] src_ptr, dst_ptr, count_out;
    logic        flag_pv, flag_z, busy, done;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    bit sb_on = 1'b1;
    logic pv_m = 1'b0;
    logic z_m  = 1'b0;
    logic [24:0] sb_q[$];

    initial clk = 1'b0;
    always #5 clk = ~clk;

    blk_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .step_down(step_down), .repeat_mode(repeat_mode),
        .src_init(src_init), .dst_init(dst_init), .count_init(count_init),
        .acc(acc), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_req(io_req),
        .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .count_out(count_out), .flag_pv(flag_pv), .flag_z(flag_z),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] io_byte(input logic [15:0] a);
        return a[7:0] + a[15:8] + 8'h5A;
    endfunction

    // Memory and port models: read data one cycle after the request
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem_byte(mem_addr);
        if (io_req && !io_we)   io_rdata  <= io_byte(io_addr);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected writes as the design produces them
    always @(negedge clk) begin
        logic [24:0] obs;
        logic [24:0] expv;
        bit hit;
        hit = 1'b0;
        obs = '0;
        if (mem_req && mem_we) begin hit = 1'b1; obs = {1'b0, mem_addr, mem_wdata}; end
        if (io_req && io_we)   begin hit = 1'b1; obs = {1'b1, io_addr, io_wdata}; end
        if (hit) begin
            wr_seen++;
            if (sb_on) begin
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R3/R4 port write not expected: actual %h expected none", obs);
                end else begin
                    expv = sb_q.pop_front();
                    chk("R3 R5 R6 port write {io,addr,data}", 32'(obs), 32'(expv));
                end
            end
        end
    end

    task automatic run_op(input blk_op_e op, input bit dn, input bit rp,
                          input logic [15:0] s0, input logic [15:0] d0,
                          input logic [15:0] c0, input logic [7:0] a,
                          input bit poke, input string tag);
        logic [15:0] s, d, c;
        logic [7:0]  b, byt;
        bit cont, m;
        int iters, busy_cyc, wr_start, guard;
        s = s0; d = d0; c = c0; iters = 0; cont = 1'b1;
        while (cont) begin
            iters++;
            unique case (op)
                OP_COPY: begin
                    if (sb_on) sb_q.push_back({1'b0, d, mem_byte(s)});
                    s = dn ? s - 16'd1 : s + 16'd1;
                    d = dn ? d - 16'd1 : d + 16'd1;
                    c = c - 16'd1; pv_m = (c != 0); cont = rp && (c != 0);
                end
                OP_SEARCH: begin
                    m = (mem_byte(s) == a);
                    s = dn ? s - 16'd1 : s + 16'd1;
                    c = c - 16'd1; pv_m = (c != 0); z_m = m;
                    cont = rp && (c != 0) && !m;
                end
                OP_IN: begin
                    if (sb_on) sb_q.push_back({1'b0, s, io_byte(c)});
                    s = dn ? s - 16'd1 : s + 16'd1;
                    b = c[15:8] - 8'd1; c = {b, c[7:0]};
                    z_m = (b == 0); cont = rp && (b != 0);
                end
                OP_OUT: begin
                    byt = mem_byte(s);
                    b = c[15:8] - 8'd1; c = {b, c[7:0]};
                    if (sb_on) sb_q.push_back({1'b1, c, byt});
                    s = dn ? s - 16'd1 : s + 16'd1;
                    z_m = (b == 0); cont = rp && (b != 0);
                end
            endcase
        end

        wr_start = wr_seen;
        @(negedge clk);
        op_sel = op; step_down = dn; repeat_mode = rp;
        src_init = s0; dst_init = d0; count_init = c0; acc = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cyc = 0; guard = 0;
        while (!done && guard < 140000) begin
            if (busy) busy_cyc++;
            if (poke && busy_cyc == 3) begin
                start = 1'b1; src_init = 16'hDEAD; count_init = 16'h0001;
            end else begin
                start = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        chk({tag, " done seen (R11)"}, 32'(done), 32'd1);
        chk({tag, " src_ptr (R3 R4 R5 R6)"}, 32'(src_ptr), 32'(s));
        chk({tag, " dst_ptr (R3)"}, 32'(dst_ptr), 32'(d));
        chk({tag, " count_out (R7 R8 R9)"}, 32'(count_out), 32'(c));
        chk({tag, " flag_pv (R3 R4 R12)"}, 32'(flag_pv), 32'(pv_m));
        chk({tag, " flag_z (R4 R5 R12)"}, 32'(flag_z), 32'(z_m));
        chk({tag, " busy cycles = 2 per iteration (R11)"}, 32'(busy_cyc), 32'(2 * iters));
        chk({tag, " all expected writes seen"}, 32'(sb_q.size()), 32'd0);
        if (!sb_on) chk({tag, " write count (R10)"}, 32'(wr_seen - wr_start), 32'(iters));
        @(negedge clk);
        chk({tag, " done single pulse (R11)"}, 32'(done), 32'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op_sel = 2'd0; step_down = 1'b0;
        repeat_mode = 1'b0; src_init = '0; dst_init = '0; count_init = '0;
        acc = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 requests", 32'({mem_req, io_req}), 32'd0);
        chk("R1 registers", 32'(src_ptr | dst_ptr | count_out), 32'd0);
        chk("R1 flags", 32'({flag_pv, flag_z}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R7: single copy upward, count 5
        run_op(OP_COPY, 1'b0, 1'b0, 16'h1000, 16'h8000, 16'd5, 8'h00, 1'b0, "R3 R7 copy up single");
        // R3 R7: single copy downward, count 1 -> pv 0
        run_op(OP_COPY, 1'b1, 1'b0, 16'h10F0, 16'h80F0, 16'd1, 8'h00, 1'b0, "R3 R7 copy down single");
        // R8 R2: repeating copy with a stray start mid-run
        run_op(OP_COPY, 1'b0, 1'b1, 16'h2200, 16'h4400, 16'd4, 8'h00, 1'b1, "R8 R2 copy repeat");
        // R4 R8: repeating search stops early on match (third byte)
        run_op(OP_SEARCH, 1'b0, 1'b1, 16'h1230, 16'h0000, 16'd6, mem_byte(16'h1232), 1'b0, "R4 R8 search match");
        // R4 R8: repeating search without a match runs to zero
        run_op(OP_SEARCH, 1'b1, 1'b1, 16'h2000, 16'h0000, 16'd3, 8'hFF, 1'b0, "R4 R8 search exhaust");
        // R7: single search from count 0 wraps to FFFF with pv 1
        run_op(OP_SEARCH, 1'b0, 1'b0, 16'h3000, 16'h0000, 16'd0, 8'hFF, 1'b0, "R7 search single zero count");
        // R5 R9 R12: repeating input, lower byte kept, pv unchanged
        run_op(OP_IN, 1'b1, 1'b1, 16'h5000, 16'h0000, 16'h0340, 8'h00, 1'b0, "R5 R9 R12 input repeat");
        // R6 R7: single output, B decremented before the port write
        run_op(OP_OUT, 1'b0, 1'b0, 16'h6000, 16'h0000, 16'h0277, 8'h00, 1'b0, "R6 R7 output single");
        // R9: repeating output from upper byte 0 gives 256 iterations
        run_op(OP_OUT, 1'b0, 1'b1, 16'h7000, 16'h0000, 16'h0012, 8'h00, 1'b0, "R9 output 256");
        // R12: copy keeps Z from the previous output
        run_op(OP_COPY, 1'b0, 1'b0, 16'h0100, 16'h0200, 16'd9, 8'h00, 1'b0, "R12 copy keeps z");
        // R10: repeating copy from count 0 runs 65536 iterations
        sb_on = 1'b0;
        run_op(OP_COPY, 1'b0, 1'b1, 16'h0040, 16'h9000, 16'd0, 8'h00, 1'b0, "R10 copy wrap");
        sb_on = 1'b1;

        finish_run();
    end

endmodule